// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is a timer counter with a parameterized width (16 bits by default). It advances once per tick of a power-of-two prescaler that runs on the peripheral clock. It has two counting shapes. In sawtooth mode it counts in one direction and wraps at the period boundary. In triangular mode it climbs to the period value and falls back to zero, again and again. Each wrap or turnaround raises an overflow or underflow event. Every event sets a sticky flag, and each flag has its own interrupt enable.

Software can start the counter, stop it, preload it and read it. It also chooses the period, the mode, the direction and the divider. An asynchronous trigger input is brought into the clock domain, and its edges are detected there. Six configuration bits decide whether a rising or a falling trigger edge starts, stops or clears the counter.

Two strobes drive downstream compare channels. The period-match strobe marks each period boundary. The valley strobe marks the trough of the triangle.

Top module: `updn_timer_core`

## Requirements
- R1: After reset the count is 0, the counter is stopped, both flags and both interrupt outputs are 0, and both strobes are 0.
- R2: With prescaler code k, where 0 <= k <= 10, a running counter advances once every 2^k clocks. The first step comes 2^k clocks after the counter starts running. Any code above 10 behaves as 10.
- R3: In sawtooth mode (tri_mode=0) with dir_up=1, the count steps 0,1,...,period. On the step at or above period it becomes 0 and an overflow event occurs.
- R4: In sawtooth mode with dir_up=0, the count steps down. On the step at 0 it reloads the period value and an underflow event occurs.
- R5: In triangular mode (tri_mode=1), dir_up is ignored. The count rises to period, and on the next step an overflow event occurs and the count becomes period-1. It then falls to 0, and on the next step an underflow event occurs and the count becomes 1. With period 0 the count stays 0 and the two events alternate.
- R6: An overflow or underflow event sets its flag one clock later. The flag stays set until a 1 on its clear input (ovf_clr or udf_clr). If an event and a clear arrive together, the event wins.
- R7: ovf_irq is high exactly when ovf_flag and ovf_ie are both high. udf_irq is high exactly when udf_flag and udf_ie are both high.
- R8: A sw_start pulse makes the counter run from the next clock, and a sw_stop pulse halts it. If both are given together, stop wins. A stopped counter holds its value.
- R9: sw_load writes load_val into the count on the next clock, whether the counter is running or stopped. A load takes priority over a counting step in the same clock and suppresses that step's event.
- R10: trig_in passes through a two-flop synchronizer and then an edge detector, so an edge acts on the third rising clock edge after it is sampled. The bits of trig_cfg select the actions: bit 0 starts on a rise, bit 1 starts on a fall, bit 2 stops on a rise, bit 3 stops on a fall, bit 4 clears on a rise, bit 5 clears on a fall.
- R11: A trigger clear sets the count to 0 and restarts triangular counting upward. It leaves the run state unchanged and takes priority over both a load and a step.
- R12: period_match pulses for one clock together with every overflow event, and with every underflow event in down-sawtooth mode. valley pulses for one clock together with every underflow event in triangular mode only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psc_sel | input | 4 | Prescaler code, divide by 2^code |
| tri_mode | input | 1 | 0 sawtooth, 1 triangular |
| dir_up | input | 1 | Sawtooth direction, 1 up, 0 down |
| period | input | 16 | Period value |
| trig_in | input | 1 | Asynchronous trigger input |
| trig_cfg | input | 6 | Trigger edge action enables (see R10) |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| sw_load | input | 1 | Software count write strobe |
| load_val | input | 16 | Value written by sw_load |
| ovf_ie | input | 1 | Overflow interrupt enable |
| udf_ie | input | 1 | Underflow interrupt enable |
| ovf_clr | input | 1 | Overflow flag clear |
| udf_clr | input | 1 | Underflow flag clear |
| count | output | 16 | Current count |
| running | output | 1 | Run state |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| ovf_irq | output | 1 | Overflow interrupt |
| udf_irq | output | 1 | Underflow interrupt |
| period_match | output | 1 | Period boundary strobe |
| valley | output | 1 | Triangular trough strobe |

## Verification
The bench builds the core with its default parameters: a 16-bit counter, a 4-bit prescaler code with a largest divider code of 10, and two synchronizer stages. The 4-bit code field also holds codes 11 to 15, so the clamp to the largest divider can be reached. The bench drives code 10 and code 13 long enough to see several steps at a divide of 1024. Periods stay small, mostly 0 to 15, so many wraps, crests, troughs and the degenerate period-0 triangle occur within a short run. A cycle-level reference model in the bench tracks the count, the run state, the flags and the strobes while random mode, direction, trigger and command stimulus runs alongside it.

// File: rtl/udt_pkg.sv
package udt_pkg;

   // trigger configuration bit positions (behavioural: decoded by the core)
   localparam int TRIG_CFG_W    = 6;
   localparam int TC_START_RISE = 0;
   localparam int TC_START_FALL = 1;
   localparam int TC_STOP_RISE  = 2;
   localparam int TC_STOP_FALL  = 3;
   localparam int TC_CLR_RISE   = 4;
   localparam int TC_CLR_FALL   = 5;

   // index of the two event flags
   localparam int EV_OVF = 0;
   localparam int EV_UDF = 1;
   localparam int EV_NUM = 2;

   typedef struct packed {
      logic start;
      logic stop;
      logic clr;
   } trig_act_t;

   function automatic trig_act_t decode_trig(input logic [TRIG_CFG_W-1:0] cfg,
                                             input logic rise,
                                             input logic fall);
      trig_act_t a;
      a.start = (cfg[TC_START_RISE] & rise) | (cfg[TC_START_FALL] & fall);
      a.stop  = (cfg[TC_STOP_RISE]  & rise) | (cfg[TC_STOP_FALL]  & fall);
      a.clr   = (cfg[TC_CLR_RISE]   & rise) | (cfg[TC_CLR_FALL]   & fall);
      return a;
   endfunction

endpackage

// File: rtl/udt_edge_sync.sv
module udt_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         hist_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
         hist_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise =  sync_q[SYNC_STAGES-1] & ~hist_q;
   assign fall = ~sync_q[SYNC_STAGES-1] &  hist_q;
endmodule

// File: rtl/udt_prescaler.sv
module udt_prescaler #(
   parameter int SEL_W    = 4,
   parameter int MAX_CODE = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = MAX_CODE;
   localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(MAX_CODE);

   logic [SEL_W-1:0] code;
   logic [DIV_W:0]   one_hot;
   logic [DIV_W-1:0] mask;
   logic [DIV_W-1:0] div_cnt;

   generate
      if ((2 ** SEL_W) - 1 > MAX_CODE) begin : g_clamp
         assign code = (sel > TOP_CODE) ? TOP_CODE : sel;
      end else begin : g_direct
         assign code = sel;
      end
   endgenerate

   assign one_hot = {{DIV_W{1'b0}}, 1'b1} << code;
   // code == MAX_CODE leaves the low part zero, so the subtraction yields all ones
   assign mask    = one_hot[DIV_W-1:0] - {{(DIV_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_cnt <= '0;
      else if (run) div_cnt <= div_cnt + {{(DIV_W-1){1'b0}}, 1'b1};
      else          div_cnt <= '0;
   end

   assign tick = run && ((div_cnt & mask) == mask);
endmodule

// File: rtl/udt_count_engine.sv
module udt_count_engine #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             tri_mode,
   input  logic             dir_up,
   input  logic [CNT_W-1:0] period,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             ovf_pulse,
   output logic             udf_pulse,
   output logic             pm_pulse,
   output logic             valley_pulse
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             falling_q;
   logic [CNT_W-1:0] below_top;
   logic [CNT_W-1:0] above_floor;

   assign below_top   = (period == '0) ? '0 : period - ONE;
   assign above_floor = (period == '0) ? '0 : ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count        <= '0;
         falling_q    <= 1'b0;
         ovf_pulse    <= 1'b0;
         udf_pulse    <= 1'b0;
         pm_pulse     <= 1'b0;
         valley_pulse <= 1'b0;
      end else begin
         ovf_pulse    <= 1'b0;
         udf_pulse    <= 1'b0;
         pm_pulse     <= 1'b0;
         valley_pulse <= 1'b0;
         if (clr) begin
            count     <= '0;
            falling_q <= 1'b0;
         end else if (load) begin
            count <= load_val;
         end else if (tick) begin
            if (tri_mode) begin
               if (!falling_q) begin
                  if (count >= period) begin
                     count     <= below_top;
                     falling_q <= 1'b1;
                     ovf_pulse <= 1'b1;
                     pm_pulse  <= 1'b1;
                  end else begin
                     count <= count + ONE;
                  end
               end else begin
                  if (count == '0) begin
                     count        <= above_floor;
                     falling_q    <= 1'b0;
                     udf_pulse    <= 1'b1;
                     valley_pulse <= 1'b1;
                  end else begin
                     count <= count - ONE;
                  end
               end
            end else if (dir_up) begin
               if (count >= period) begin
                  count     <= '0;
                  ovf_pulse <= 1'b1;
                  pm_pulse  <= 1'b1;
               end else begin
                  count <= count + ONE;
               end
            end else begin
               if (count == '0) begin
                  count     <= period;
                  udf_pulse <= 1'b1;
                  pm_pulse  <= 1'b1;
               end else begin
                  count <= count - ONE;
               end
            end
         end
      end
   end
endmodule

// File: rtl/udt_sticky_flag.sv
module udt_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic ie,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assign irq = flag & ie;
endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core
   import udt_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int PSC_SEL_W    = 4,
   parameter int PSC_MAX_CODE = 10,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PSC_SEL_W-1:0]  psc_sel,
   input  logic                  tri_mode,
   input  logic                  dir_up,
   input  logic [CNT_W-1:0]      period,
   input  logic                  trig_in,
   input  logic [TRIG_CFG_W-1:0] trig_cfg,
   input  logic                  sw_start,
   input  logic                  sw_stop,
   input  logic                  sw_load,
   input  logic [CNT_W-1:0]      load_val,
   input  logic                  ovf_ie,
   input  logic                  udf_ie,
   input  logic                  ovf_clr,
   input  logic                  udf_clr,
   output logic [CNT_W-1:0]      count,
   output logic                  running,
   output logic                  ovf_flag,
   output logic                  udf_flag,
   output logic                  ovf_irq,
   output logic                  udf_irq,
   output logic                  period_match,
   output logic                  valley
);
   // elaboration-time parameter checks
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("updn_timer_core: CNT_W must be at least 2");
      end
      if (PSC_MAX_CODE < 2 || PSC_MAX_CODE > 16) begin : g_bad_psc
         $error("updn_timer_core: PSC_MAX_CODE must lie in 2..16");
      end
      if ((2 ** PSC_SEL_W) <= PSC_MAX_CODE) begin : g_bad_sel
         $error("updn_timer_core: PSC_SEL_W too narrow for PSC_MAX_CODE");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("updn_timer_core: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      trig_rise, trig_fall, tick;
   trig_act_t act;
   logic      start_evt, stop_evt, clr_evt;
   logic      ovf_pulse, udf_pulse;

   logic [EV_NUM-1:0] ev_set, ev_clr, ev_ie, ev_flag, ev_irq;

   udt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(trig_in),
      .rise(trig_rise), .fall(trig_fall)
   );

   assign act       = decode_trig(trig_cfg, trig_rise, trig_fall);
   assign start_evt = sw_start | act.start;
   assign stop_evt  = sw_stop  | act.stop;
   assign clr_evt   = act.clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         running <= 1'b0;
      else if (stop_evt)  running <= 1'b0;
      else if (start_evt) running <= 1'b1;
   end

   udt_prescaler #(.SEL_W(PSC_SEL_W), .MAX_CODE(PSC_MAX_CODE)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(running), .sel(psc_sel), .tick(tick)
   );

   udt_count_engine #(.CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .tri_mode(tri_mode), .dir_up(dir_up), .period(period),
      .clr(clr_evt), .load(sw_load), .load_val(load_val),
      .count(count), .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse),
      .pm_pulse(period_match), .valley_pulse(valley)
   );

   assign ev_set = {udf_pulse, ovf_pulse};
   assign ev_clr = {udf_clr, ovf_clr};
   assign ev_ie  = {udf_ie, ovf_ie};

   generate
      for (genvar g = 0; g < EV_NUM; g++) begin : g_flag
         udt_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .set(ev_set[g]), .clr(ev_clr[g]), .ie(ev_ie[g]),
            .flag(ev_flag[g]), .irq(ev_irq[g])
         );
      end
   endgenerate

   assign ovf_flag = ev_flag[EV_OVF];
   assign udf_flag = ev_flag[EV_UDF];
   assign ovf_irq  = ev_irq[EV_OVF];
   assign udf_irq  = ev_irq[EV_UDF];
endmodule

// File: rtl/udt_core_checker.sv
module udt_core_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic             running,
   input logic             sw_load,
   input logic             clr_evt,
   input logic             tri_mode,
   input logic             ovf_pulse,
   input logic             udf_pulse,
   input logic             ovf_flag,
   input logic             udf_flag,
   input logic             ovf_clr,
   input logic             udf_clr,
   input logic             valley
);
   // R6
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> ovf_flag);
   // R6
   udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      udf_pulse |=> udf_flag);
   // R6
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);
   // R6
   udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (udf_flag && !udf_clr) |=> udf_flag);
   // R8
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !sw_load && !clr_evt) |=> $stable(count));
   // R11
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt |=> (count == '0));
   // R3
   up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_pulse && !$past(tri_mode)) |-> (count == '0));
   // R5
   event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_pulse && udf_pulse));
   // R12
   valley_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valley |-> udf_pulse);
endmodule

bind updn_timer_core udt_core_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .count(count), .running(running),
   .sw_load(sw_load), .clr_evt(clr_evt), .tri_mode(tri_mode),
   .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse),
   .ovf_flag(ovf_flag), .udf_flag(udf_flag),
   .ovf_clr(ovf_clr), .udf_clr(udf_clr), .valley(valley)
);

// File: tb/updn_timer_core_test.sv
`timescale 1ns/1ps
module updn_timer_core_test;
   localparam real HALF = 2.5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  psc_sel = '0;
   logic        tri_mode = 1'b0, dir_up = 1'b1;
   logic [15:0] period = 16'd5;
   logic        trig_in = 1'b0;
   logic [5:0]  trig_cfg = '0;
   logic        sw_start = 0, sw_stop = 0, sw_load = 0;
   logic [15:0] load_val = '0;
   logic        ovf_ie = 0, udf_ie = 0, ovf_clr = 0, udf_clr = 0;
   logic [15:0] count;
   logic        running, ovf_flag, udf_flag, ovf_irq, udf_irq, period_match, valley;

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 0;

   always #(HALF) clk = ~clk;

   updn_timer_core uut (
      .clk(clk), .rst_n(rst_n), .psc_sel(psc_sel), .tri_mode(tri_mode),
      .dir_up(dir_up), .period(period), .trig_in(trig_in), .trig_cfg(trig_cfg),
      .sw_start(sw_start), .sw_stop(sw_stop), .sw_load(sw_load), .load_val(load_val),
      .ovf_ie(ovf_ie), .udf_ie(udf_ie), .ovf_clr(ovf_clr), .udf_clr(udf_clr),
      .count(count), .running(running), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
      .ovf_irq(ovf_irq), .udf_irq(udf_irq), .period_match(period_match), .valley(valley)
   );

   // ---------------- reference model built from the requirements ----------------
   logic [2:0]  m_sync;   // [0] first stage, [1] second stage, [2] history
   int          m_psc;
   bit          m_run, m_down, m_ovf_e, m_udf_e, m_pm, m_val, m_ovf_f, m_udf_f;
   logic [15:0] m_cnt;

   function automatic int div_of(input logic [3:0] code);
      return 1 << ((code > 4'd10) ? 10 : int'(code));   // R2 clamp
   endfunction

   always @(posedge clk) begin
      bit rise, fall, tick, st, sp, cl;
      int dv;
      if (!rst_n) begin
         m_sync = '0; m_psc = 0; m_run = 0; m_down = 0; m_cnt = '0;
         m_ovf_e = 0; m_udf_e = 0; m_pm = 0; m_val = 0; m_ovf_f = 0; m_udf_f = 0;
      end else begin
         rise   = m_sync[1] & ~m_sync[2];
         fall   = ~m_sync[1] & m_sync[2];
         m_sync = {m_sync[1:0], trig_in};
         dv     = div_of(psc_sel);
         tick   = m_run && ((m_psc % dv) == dv - 1);
         m_psc  = m_run ? (m_psc + 1) % 1024 : 0;
         st = sw_start | (trig_cfg[0] & rise) | (trig_cfg[1] & fall);
         sp = sw_stop  | (trig_cfg[2] & rise) | (trig_cfg[3] & fall);
         cl = (trig_cfg[4] & rise) | (trig_cfg[5] & fall);
         m_ovf_f = m_ovf_e ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf_f);
         m_udf_f = m_udf_e ? 1'b1 : (udf_clr ? 1'b0 : m_udf_f);
         m_ovf_e = 0; m_udf_e = 0; m_pm = 0; m_val = 0;
         if (cl) begin
            m_cnt = '0; m_down = 0;
         end else if (sw_load) begin
            m_cnt = load_val;
         end else if (tick) begin
            if (tri_mode) begin
               if (!m_down) begin
                  if (m_cnt >= period) begin
                     m_cnt = (period == 0) ? 16'd0 : period - 16'd1;
                     m_down = 1; m_ovf_e = 1; m_pm = 1;
                  end else m_cnt = m_cnt + 16'd1;
               end else begin
                  if (m_cnt == 0) begin
                     m_cnt = (period == 0) ? 16'd0 : 16'd1;
                     m_down = 0; m_udf_e = 1; m_val = 1;
                  end else m_cnt = m_cnt - 16'd1;
               end
            end else if (dir_up) begin
               if (m_cnt >= period) begin
                  m_cnt = '0; m_ovf_e = 1; m_pm = 1;
               end else m_cnt = m_cnt + 16'd1;
            end else begin
               if (m_cnt == 0) begin
                  m_cnt = period; m_udf_e = 1; m_pm = 1;
               end else m_cnt = m_cnt - 16'd1;
            end
         end
         m_run = sp ? 1'b0 : (st ? 1'b1 : m_run);
      end
   end

   // ---------------- checking ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(count == m_cnt, cur_req, "count", int'(count), int'(m_cnt));
      check(running == m_run, cur_req, "running", int'(running), int'(m_run));
      check(ovf_flag == m_ovf_f, "R6", "ovf_flag", int'(ovf_flag), int'(m_ovf_f));
      check(udf_flag == m_udf_f, "R6", "udf_flag", int'(udf_flag), int'(m_udf_f));
      check(ovf_irq == (m_ovf_f & ovf_ie), "R7", "ovf_irq", int'(ovf_irq), int'(m_ovf_f & ovf_ie));
      check(udf_irq == (m_udf_f & udf_ie), "R7", "udf_irq", int'(udf_irq), int'(m_udf_f & udf_ie));
      check(period_match == m_pm, "R12", "period_match", int'(period_match), int'(m_pm));
      check(valley == m_val, "R12", "valley", int'(valley), int'(m_val));
   endtask

   task automatic cyc(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
      end
   endtask

   function automatic bit chance(input int pct);
      return $urandom_range(99) < pct;
   endfunction

   task automatic pulse_start(); sw_start = 1; cyc(); sw_start = 0; endtask
   task automatic pulse_stop();  sw_stop  = 1; cyc(); sw_stop  = 0; endtask

   // ---------------- watchdog ----------------
   initial begin
      #(HALF * 2 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'h00C0FFEE));
      cyc(4);
      rst_n = 1;
      cyc();
      // R1 reset state
      check(count == 0, "R1", "count after reset", int'(count), 0);
      check(!running, "R1", "running after reset", int'(running), 0);
      check(!ovf_flag && !udf_flag, "R1", "flags after reset", int'({ovf_flag, udf_flag}), 0);
      check(!period_match && !valley, "R1", "strobes after reset", int'({period_match, valley}), 0);

      // R3 up sawtooth
      cur_req = "R3";
      tri_mode = 0; dir_up = 1; period = 5; psc_sel = 0;
      pulse_start();
      cyc(30);

      // R2 prescaler codes, including top code and clamp
      cur_req = "R2";
      psc_sel = 2;  cyc(40);
      psc_sel = 10; cyc(2200);
      psc_sel = 13; cyc(1100);
      psc_sel = 0;

      // R4 down sawtooth
      cur_req = "R4";
      psc_sel = 1; dir_up = 0; period = 6; cyc(40);
      psc_sel = 0;

      // R6 / R7 flags and interrupts
      cur_req = "R6";
      ovf_ie = 1; udf_ie = 1;
      for (int i = 0; i < 40; i++) begin
         ovf_clr = chance(20); udf_clr = chance(20); cyc();
      end
      ovf_clr = 0; udf_clr = 0;
      cur_req = "R7";
      ovf_ie = 0; cyc(10); ovf_ie = 1; udf_ie = 0; cyc(10);

      // R5 triangular, direction ignored, period 0 and 1 corners
      cur_req = "R5";
      tri_mode = 1; period = 4;
      for (int i = 0; i < 60; i++) begin dir_up = chance(50); cyc(); end
      period = 0; cyc(20);
      period = 1; cyc(20);
      period = 4;

      // R8 stop, hold, start, simultaneous start and stop
      cur_req = "R8";
      pulse_stop(); cyc(10);
      check(!running, "R8", "stopped", int'(running), 0);
      sw_start = 1; sw_stop = 1; cyc(); sw_start = 0; sw_stop = 0;
      cyc(5);
      check(!running, "R8", "stop wins", int'(running), 0);
      pulse_start(); cyc(10);

      // R9 load while running and while stopped
      cur_req = "R9";
      tri_mode = 0; dir_up = 1; period = 9;
      load_val = 3; sw_load = 1; cyc(); sw_load = 0;
      check(count == 3, "R9", "load running", int'(count), 3);
      cyc(8);
      pulse_stop();
      load_val = 7; sw_load = 1; cyc(); sw_load = 0;
      check(count == 7, "R9", "load stopped", int'(count), 7);
      cyc(3);

      // R10 trigger start on rise, stop on fall
      cur_req = "R10";
      trig_cfg = 6'b001001;
      trig_in = 1; cyc(2);
      check(!running, "R10", "start not yet", int'(running), 0);
      cyc();
      check(running, "R10", "start on rise", int'(running), 1);
      cyc(12);
      trig_in = 0; cyc(6);
      check(!running, "R10", "stop on fall", int'(running), 0);
      trig_cfg = 6'b000110;   // start on fall, stop on rise
      trig_in = 1; cyc(6); trig_in = 0; cyc(10); trig_in = 1; cyc(6);

      // R11 trigger clear on rise and fall
      cur_req = "R11";
      trig_in = 0; pulse_start();
      trig_cfg = 6'b110000; tri_mode = 1; period = 12;
      cyc(15);
      trig_in = 1; cyc(8); trig_in = 0; cyc(8);
      sw_load = 1; load_val = 9; trig_in = 1; cyc(2); sw_load = 0; cyc(5);

      // R12 and mixed random traffic
      cur_req = "R12";
      for (int i = 0; i < 5000; i++) begin
         if (chance(2)) tri_mode = chance(50);
         if (chance(3)) dir_up   = chance(50);
         if (chance(2)) period   = 16'($urandom_range(15));
         if (chance(2)) psc_sel  = chance(80) ? 4'd0 : 4'($urandom_range(3));
         if (chance(2)) trig_cfg = 6'($urandom_range(63));
         if (chance(5)) trig_in  = ~trig_in;
         sw_start = chance(4); sw_stop = chance(2);
         sw_load  = chance(2); load_val = 16'($urandom_range(20));
         ovf_clr  = chance(10); udf_clr = chance(10);
         ovf_ie   = chance(50); udf_ie  = chance(50);
         cyc();
      end
      sw_start = 0; sw_stop = 0; sw_load = 0; ovf_clr = 0; udf_clr = 0;
      cyc(4);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule